// File: doc/BRIEF.md
# Selectable-Order Divide-by-96 Clock Divider

This block turns a fast input clock into an output square wave at one ninety-sixth of its rate, so a 9.6 MHz input yields 100 kHz. The division is done by a cascade of small synchronous counters. Each counter advances only when the counter before it wraps. Every flip-flop runs on the one input clock, and no counter output is ever used as a clock. A one-clock terminal-count strobe marks the end of every 96-clock period.

Three stage orders are offered, and the order decides the output duty cycle. The first is a divide-by-3 followed by five divide-by-2 stages, giving a square wave. The second is a divide-by-16 followed by a divide-by-6, giving a two-thirds-high wave. The third is divide-by-8, then divide-by-6, then a closing divide-by-2, also giving a square wave. The order is taken from `mode_sel` only while the synchronous clear is applied. It then holds until the next clear, which restarts the period. An asynchronous active-low reset, released in step with the clock, puts the block into the first order with every counter at zero.

In what follows, k is the number of rising clock edges since the last edge at which `sync_clr` was sampled high, or since reset release. "Phase" means k mod 96.

Top module: `div96_cascade`

## Requirements
- R1: While `rst_n` is low, `clk_out` and `tc_pulse` are 0. After release, the block runs in the `mode_sel`=00 order without any clear.
- R2: `mode_sel`=00 (divide-by-3, then five divide-by-2): `clk_out` is 0 for phases 0..47 and 1 for phases 48..95, giving 48 high clocks per period.
- R3: `mode_sel`=01 (divide-by-16, then divide-by-6): `clk_out` is 1 while the divide-by-6 stage holds 2..5. It is therefore 0 for phases 0..31 and 1 for phases 32..95, giving 64 high clocks per period.
- R4: `mode_sel`=10 (divide-by-8, divide-by-6, divide-by-2): `clk_out` is 0 for phases 0..47 and 1 for phases 48..95.
- R5: `mode_sel`=11 behaves exactly as 00.
- R6: `tc_pulse` is 1 exactly when the phase is 95, in every mode.
- R7: `mode_sel` is sampled only at an edge where `sync_clr` is 1. Changes at other times do not affect `clk_out` or `tc_pulse`.
- R8: An edge with `sync_clr`=1 zeroes every stage, overriding any count. Right after it, `clk_out` and `tc_pulse` are 0 and the phase is 0.
- R9: Every period is 96 clocks long, with exactly one `tc_pulse` and the high time its mode defines. `clk_out` is 0 on the clock that follows a `tc_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_clr | input | 1 | Synchronous clear; also loads the stage order |
| mode_sel | input | 2 | Stage order: 00/11 div3+5xdiv2, 01 div16+div6, 10 div8+div6+div2 |
| clk_out | output | 1 | Divided output, one period per 96 input clocks |
| tc_pulse | output | 1 | One-clock strobe on the last clock of each period |

## Verification
The bench goes after the phase at which each order flips its output: 48 for the square-wave orders and 32 for the two-thirds order. A wrong threshold or a stage taken from the wrong chain would move that edge or change the high count of a period. It clears in the middle of a period and re-selects the order there. A clear that lost to counting would leave a stale phase, and one that failed to load the order would keep the old duty cycle. It also toggles `mode_sel` between clears and runs the unused 11 code. A design that sampled the selector continuously or left 11 undecoded would change duty or stop, and a misplaced strobe would show up as zero or two pulses per period.

// File: rtl/div96_pkg.sv
`timescale 1ns/1ps
package div96_pkg;
  localparam int TOTAL_RATIO  = 96;
  localparam int A_ODD_RATIO  = 3;
  localparam int A_BIN_STAGES = 5;
  localparam int B_PRE_RATIO  = 16;
  localparam int B_POST_RATIO = 6;
  localparam int B_HIGH_FROM  = 2;
  localparam int C_PRE_RATIO  = 8;
  localparam int C_MID_RATIO  = 6;
  localparam int C_POST_RATIO = 2;

  typedef enum logic [1:0] {
    ORD_BINARY  = 2'b00,
    ORD_SIXTEEN = 2'b01,
    ORD_HALVED  = 2'b10
  } order_e;

  function automatic order_e decode_order(input logic [1:0] sel);
    case (sel)
      2'b01:   return ORD_SIXTEEN;
      2'b10:   return ORD_HALVED;
      default: return ORD_BINARY;
    endcase
  endfunction
endpackage

// File: rtl/div96_rst_sync.sv
`timescale 1ns/1ps
module div96_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/div96_stage.sv
`timescale 1ns/1ps
module div96_stage #(
  parameter int RATIO   = 2,
  parameter int HI_FROM = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en_in,
  output logic en_out,
  output logic lvl
);
  localparam int W = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [W-1:0] LAST = W'(RATIO - 1);
  localparam logic [W-1:0] HI   = W'(HI_FROM);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (en_in) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign en_out = en_in & wrap;
  assign lvl    = (cnt_q >= HI);
endmodule

// File: rtl/div96_cascade.sv
`timescale 1ns/1ps
module div96_cascade
  import div96_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_clr,
  input  logic [1:0] mode_sel,
  output logic       clk_out,
  output logic       tc_pulse
);
  localparam int A_PRODUCT = A_ODD_RATIO * (1 << A_BIN_STAGES);
  localparam int B_PRODUCT = B_PRE_RATIO * B_POST_RATIO;
  localparam int C_PRODUCT = C_PRE_RATIO * C_MID_RATIO * C_POST_RATIO;

  initial begin
    if (A_PRODUCT != TOTAL_RATIO || B_PRODUCT != TOTAL_RATIO || C_PRODUCT != TOTAL_RATIO)
      $error("stage ratios do not multiply to the total ratio");
  end

  logic   rst_sync_n;
  order_e order_q;
  order_e order_d;

  div96_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    order_d = order_q;
    if (sync_clr) order_d = decode_order(mode_sel);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) order_q <= ORD_BINARY;
    else             order_q <= order_d;
  end

  logic run_a, run_b, run_c;
  assign run_a = (order_q == ORD_BINARY);
  assign run_b = (order_q == ORD_SIXTEEN);
  assign run_c = (order_q == ORD_HALVED);

  // Order A: divide-by-3 then a generated run of divide-by-2 stages
  logic [A_BIN_STAGES+1:0] a_en;
  logic a_out;
  logic a_odd_lvl_unused;
  assign a_en[0] = run_a;

  div96_stage #(.RATIO(A_ODD_RATIO), .HI_FROM(1)) u_a_odd (
    .clk(clk), .rst_n(rst_sync_n), .clr(sync_clr), .en_in(a_en[0]),
    .en_out(a_en[1]), .lvl(a_odd_lvl_unused)
  );

  for (genvar i = 0; i < A_BIN_STAGES; i++) begin : g_a_bin
    logic lvl_or_unused;
    div96_stage #(.RATIO(2), .HI_FROM(1)) u_bin (
      .clk(clk), .rst_n(rst_sync_n), .clr(sync_clr), .en_in(a_en[i+1]),
      .en_out(a_en[i+2]), .lvl(lvl_or_unused)
    );
    if (i == A_BIN_STAGES - 1) begin : g_tap
      assign a_out = lvl_or_unused;
    end
  end

  // Order B: divide-by-16 then divide-by-6, high from count 2
  logic b_mid_en, b_tc, b_out, b_pre_lvl_unused;

  div96_stage #(.RATIO(B_PRE_RATIO), .HI_FROM(1)) u_b_pre (
    .clk(clk), .rst_n(rst_sync_n), .clr(sync_clr), .en_in(run_b),
    .en_out(b_mid_en), .lvl(b_pre_lvl_unused)
  );
  div96_stage #(.RATIO(B_POST_RATIO), .HI_FROM(B_HIGH_FROM)) u_b_post (
    .clk(clk), .rst_n(rst_sync_n), .clr(sync_clr), .en_in(b_mid_en),
    .en_out(b_tc), .lvl(b_out)
  );

  // Order C: divide-by-8, divide-by-6, then a closing divide-by-2
  logic c_en1, c_en2, c_tc, c_out, c_pre_lvl_unused, c_mid_lvl_unused;

  div96_stage #(.RATIO(C_PRE_RATIO), .HI_FROM(1)) u_c_pre (
    .clk(clk), .rst_n(rst_sync_n), .clr(sync_clr), .en_in(run_c),
    .en_out(c_en1), .lvl(c_pre_lvl_unused)
  );
  div96_stage #(.RATIO(C_MID_RATIO), .HI_FROM(1)) u_c_mid (
    .clk(clk), .rst_n(rst_sync_n), .clr(sync_clr), .en_in(c_en1),
    .en_out(c_en2), .lvl(c_mid_lvl_unused)
  );
  div96_stage #(.RATIO(C_POST_RATIO), .HI_FROM(1)) u_c_post (
    .clk(clk), .rst_n(rst_sync_n), .clr(sync_clr), .en_in(c_en2),
    .en_out(c_tc), .lvl(c_out)
  );

  always_comb begin
    case (order_q)
      ORD_SIXTEEN: begin clk_out = b_out; tc_pulse = b_tc;                end
      ORD_HALVED:  begin clk_out = c_out; tc_pulse = c_tc;                end
      default:     begin clk_out = a_out; tc_pulse = a_en[A_BIN_STAGES+1]; end
    endcase
  end
endmodule

// File: rtl/div96_checker.sv
`timescale 1ns/1ps
module div96_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_clr,
  input logic [1:0] mode_sel,
  input logic       clk_out,
  input logic       tc_pulse
);
  logic [6:0] ph_q;
  logic [1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      sel_q <= 2'b00;
    end else if (sync_clr) begin
      ph_q  <= '0;
      sel_q <= (mode_sel == 2'b11) ? 2'b00 : mode_sel;
    end else begin
      ph_q  <= (ph_q == 7'd95) ? 7'd0 : ph_q + 7'd1;
    end
  end

  AST_TC_AT_PHASE_95: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse == (ph_q == 7'd95)); // R6
  AST_SQUARE_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'b00) |-> (clk_out == (ph_q >= 7'd48))); // R2
  AST_TWO_THIRDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'b01) |-> (clk_out == (ph_q >= 7'd32))); // R3
  AST_SQUARE_HALVED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 2'b10) |-> (clk_out == (ph_q >= 7'd48))); // R4
  AST_CLEAR_GOES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (!clk_out && !tc_pulse)); // R8
  AST_LOW_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_pulse && !sync_clr) |=> !clk_out); // R9
endmodule

bind div96_cascade div96_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sync_clr(sync_clr), .mode_sel(mode_sel),
  .clk_out(clk_out), .tc_pulse(tc_pulse)
);

// File: tb/sim_div96_cascade.sv
`timescale 1ns/1ps
module sim_div96_cascade;
  logic       clk;
  logic       rst_n;
  logic       sync_clr;
  logic [1:0] mode_sel;
  logic       clk_out;
  logic       tc_pulse;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  int    k = 0;
  int    hi_cnt = 0;
  int    tc_cnt = 0;
  logic [1:0] cur_mode = 2'b00;
  string tag_override = "";

  div96_cascade u0 (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .mode_sel(mode_sel),
    .clk_out(clk_out), .tc_pulse(tc_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit exp_out(input logic [1:0] m, input int kk);
    int mm = kk % 96;
    if (m == 2'b01) return (mm >= 32);
    return (mm >= 48);
  endfunction

  function automatic int exp_high(input logic [1:0] m);
    return (m == 2'b01) ? 64 : 48;
  endfunction

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (mode=%0d k=%0d)", req, act, exp, cur_mode, k);
    end
  endtask

  task automatic start(input logic [1:0] m);
    @(negedge clk);
    sync_clr = 1'b1;
    mode_sel = m;
    @(negedge clk);
    sync_clr = 1'b0;
    cur_mode = m;
    k = 0;
    hi_cnt = 0;
    tc_cnt = 0;
  endtask

  task automatic step(input bit noise);
    int    mm = k % 96;
    string rq;
    bit    e;
    rq = mode_req(cur_mode);
    if (tag_override != "") rq = tag_override;
    if (noise) rq = "R7";
    if (k == 0) rq = "R8";
    e = exp_out(cur_mode, k);
    chk(clk_out === e, rq, int'(clk_out), int'(e));
    chk(tc_pulse === (mm == 95), "R6", int'(tc_pulse), int'(mm == 95));
    hi_cnt += int'(clk_out);
    tc_cnt += int'(tc_pulse);
    if (mm == 95) begin
      chk(hi_cnt == exp_high(cur_mode), (noise ? "R7" : mode_req(cur_mode)), hi_cnt, exp_high(cur_mode));
      chk(tc_cnt == 1, "R9", tc_cnt, 1);
      hi_cnt = 0;
      tc_cnt = 0;
    end
    if (noise) mode_sel = 2'($urandom);
    @(negedge clk);
    k++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed_v;
    bit found;
    seed_v = $urandom(32'd20417);
    rst_n = 1'b0;
    sync_clr = 1'b0;
    mode_sel = 2'b10;

    // R1: outputs low during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(clk_out === 1'b0, "R1", int'(clk_out), 0);
      chk(tc_pulse === 1'b0, "R1", int'(tc_pulse), 0);
    end

    // R1: after release, default order runs without a clear
    rst_n = 1'b1;
    found = 0;
    for (int i = 0; i < 200 && !found; i++) begin
      @(negedge clk);
      if (tc_pulse === 1'b1) found = 1;
    end
    chk(found, "R1", int'(found), 1);
    @(negedge clk);
    cur_mode = 2'b00;
    k = 0;
    hi_cnt = 0;
    tc_cnt = 0;
    tag_override = "R1";
    for (int i = 0; i < 192; i++) step(1'b0);
    tag_override = "";

    // Directed: each order for three full periods (R2..R5, R6, R9)
    for (int m = 0; m < 4; m++) begin
      start(2'(m));
      for (int i = 0; i < 288; i++) step(1'b0);
    end

    // R7: selector wiggled between clears
    start(2'b01);
    for (int i = 0; i < 200; i++) step(1'b1);
    start(2'b10);
    for (int i = 0; i < 200; i++) step(1'b1);

    // R8: clear near the period edges and mid-high
    start(2'b00);
    for (int i = 0; i < 95; i++) step(1'b0);
    start(2'b01);
    for (int i = 0; i < 70; i++) step(1'b0);
    start(2'b10);
    for (int i = 0; i < 96; i++) step(1'b0);

    // Random orders, lengths and selector noise
    for (int it = 0; it < 24; it++) begin
      int  n;
      bit  nz;
      start(2'($urandom));
      n  = 1 + int'($urandom % 300);
      nz = 1'($urandom);
      for (int i = 0; i < n; i++) step(nz);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule